// File: doc/BRIEF.md
# Compact Float to Single-Precision Expander

This block widens a compact low-precision floating-point code into an IEEE 754 single-precision word, so that ordinary 32-bit arithmetic can consume values produced by a narrow-format quantizer. The code holds a sign bit, an exponent field and a mantissa field. The exponent field encodes only negative exponents. Its window is moved further down by a compile-time offset, and the block uses the same exponent width, mantissa width and offset as the quantizer that produces the codes.

A code with a nonzero exponent field is normal. Its exponent is re-biased into the single-precision range and its mantissa is zero-extended on the right. A code with a zero exponent field and a nonzero mantissa is subnormal: its hidden bit is zero. It is renormalized by shifting the mantissa left until the leading one reaches the hidden position, and the exponent is lowered by one for each position shifted. An all-zero magnitude gives a signed zero.

The result is registered once and qualified by a valid flag. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `lpf_expander`

## Requirements
- R1: While reset is asserted, out_valid and out_word are 0, and both clear at once on reset assertion. After reset is released, out_valid stays 0 until an input is accepted.
- R2: out_valid equals in_valid delayed by one clock. out_word takes the converted value of in_code in that same cycle. Back-to-back valid inputs give back-to-back results.
- R3: Bit 31 of out_word always equals the top bit of in_code (bit 7 with the default widths), for zero, normal and subnormal codes.
- R4: A normal code has a nonzero exponent field k, held in in_code bits 6:4 by default. It gives the single-precision exponent field k + 127 - (2^EXP_W - 1) - EXP_OFS, which is k + 118 with the defaults.
- R5: For a normal code, the mantissa (in_code bits 3:0 by default) appears in out_word bits 22:19, and bits 18:0 are zero.
- R6: A code whose exponent and mantissa fields are both zero gives a signed zero: out_word bits 30:0 are 0 and bit 31 carries the sign.
- R7: A subnormal code (k = 0, mantissa m nonzero) with its leading one at mantissa bit p gives exponent field 119 - (4 - p) with the defaults. The fraction is the mantissa bits below p, moved to the top of bits 22:19, with zeros below them.
- R8: Without in_valid, out_word holds its value whatever in_code does, and out_valid is 0.
- R9: Each of the 256 default codes is reproduced exactly. A normal code gives (-1)^s x (1 + m/16) x 2^(k-9). A subnormal code or zero gives (-1)^s x (m/16) x 2^-8.
- R10: out_word never has exponent field 0xFF, and never has a zero exponent field with a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies in_code for this cycle |
| in_code | input | 1+EXP_W+MAN_W | Compact code: sign, exponent field, mantissa field from MSB down |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_word | output | 32 | Single-precision result |

## Verification
Hand-worked codes are chosen to separate the three decode paths. The normal codes use the lowest, highest and a middle exponent, which exposes a wrong re-bias constant or a misplaced mantissa. The subnormal codes have their leading one at every mantissa position, so each shift distance and its matching exponent decrement is tried once. Both signed zeros are included. An exhaustive pass over all 256 codes compares the output, turned back into a real number, against a value computed from the format definition. A hold test changes in_code with valid low, and a back-to-back pair checks pipeline alignment.

// File: rtl/lpf_pkg.sv
`timescale 1ns/1ps
package lpf_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_BIAS   = 127;

  typedef struct packed {
    logic                 sign;
    logic [SP_EXP_W-1:0]  expo;
    logic [SP_FRAC_W-1:0] frac;
  } sp_word_t;
endpackage

// File: rtl/lpf_rst_sync.sv
`timescale 1ns/1ps
module lpf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lpf_lead_one.sv
`timescale 1ns/1ps
module lpf_lead_one #(
  parameter  int W     = 4,
  localparam int IDX_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  // Highest set bit wins: later iterations overwrite earlier ones.
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign found = |vec;
endmodule

// File: rtl/lpf_decode.sv
`timescale 1ns/1ps
module lpf_decode
  import lpf_pkg::*;
#(
  parameter  int EXP_W   = 3,
  parameter  int MAN_W   = 4,
  parameter  int EXP_OFS = 2,
  localparam int CODE_W  = 1 + EXP_W + MAN_W
) (
  input  logic [CODE_W-1:0] code,
  output sp_word_t          word
);
  localparam int IDX_W  = $clog2(MAN_W + 1);
  localparam int PAD_W  = SP_FRAC_W - MAN_W;
  localparam int REBIAS = SP_BIAS - ((1 << EXP_W) - 1) - EXP_OFS;

  logic             sgn;
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic [IDX_W-1:0] lead_idx;
  logic             lead_found;
  logic [IDX_W-1:0] shamt;
  logic [MAN_W-1:0] man_renorm;

  assign sgn   = code[CODE_W-1];
  assign exp_f = code[CODE_W-2 -: EXP_W];
  assign man_f = code[MAN_W-1:0];

  lpf_lead_one #(.W(MAN_W)) u_lead (
    .vec   (man_f),
    .idx   (lead_idx),
    .found (lead_found)
  );

  // Distance that moves the leading one into the hidden position.
  assign shamt      = IDX_W'(MAN_W) - lead_idx;
  assign man_renorm = MAN_W'(man_f << shamt);

  always_comb begin
    word.sign = sgn;
    if (exp_f != '0) begin
      word.expo = SP_EXP_W'(int'(exp_f) + REBIAS);
      word.frac = {man_f, {PAD_W{1'b0}}};
    end else if (!lead_found) begin
      word.expo = '0;
      word.frac = '0;
    end else begin
      word.expo = SP_EXP_W'(1 + REBIAS - int'(shamt));
      word.frac = {man_renorm, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/lpf_expander.sv
`timescale 1ns/1ps
module lpf_expander
  import lpf_pkg::*;
#(
  parameter  int EXP_W   = 3,
  parameter  int MAN_W   = 4,
  parameter  int EXP_OFS = 2,
  localparam int CODE_W  = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [31:0]       out_word
);
  logic     rst_sync_n;
  sp_word_t dec_word;
  logic     vld_d, vld_q;
  logic [31:0] word_d, word_q;

  lpf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpf_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .EXP_OFS(EXP_OFS)) u_dec (
    .code (in_code),
    .word (dec_word)
  );

  // Next-state logic with an explicit load enable.
  always_comb begin
    vld_d  = in_valid;
    word_d = word_q;
    if (in_valid) word_d = dec_word;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;
endmodule

// File: rtl/lpf_expander_chk.sv
`timescale 1ns/1ps
module lpf_expander_chk #(
  parameter  int EXP_W   = 3,
  parameter  int MAN_W   = 4,
  parameter  int EXP_OFS = 2,
  localparam int CODE_W  = 1 + EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic [31:0]       out_word
);
  localparam int PAD_W   = 23 - MAN_W;
  localparam int REBIAS  = 127 - ((1 << EXP_W) - 1) - EXP_OFS;
  localparam logic [7:0] EBIAS8 = 8'(REBIAS);
  localparam logic [7:0] SUB_HI = 8'(REBIAS);
  localparam logic [7:0] SUB_LO = 8'(REBIAS + 1 - MAN_W);

  logic [EXP_W-1:0] c_exp;
  logic [MAN_W-1:0] c_man;
  assign c_exp = in_code[CODE_W-2 -: EXP_W];
  assign c_man = in_code[MAN_W-1:0];

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> !out_valid && out_word == '0);

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_sign_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_word[31] == $past(in_code[CODE_W-1]));

  assert_norm_exp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && c_exp != '0 |=> out_word[30:23] == EBIAS8 + 8'($past(c_exp)));

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_word[PAD_W-1:0] == '0);

  assert_signed_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && c_exp == '0 && c_man == '0 |=> out_word[30:0] == '0);

  assert_sub_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && c_exp == '0 && c_man != '0 |=>
      out_word[30:23] <= SUB_HI && out_word[30:23] >= SUB_LO);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));

  assert_no_special_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_word[30:23] != 8'hFF &&
      (out_word[30:23] != 8'h00 || out_word[22:0] == '0));
endmodule

bind lpf_expander lpf_expander_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .EXP_OFS(EXP_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_code   (in_code),
  .out_valid (out_valid),
  .out_word  (out_word)
);

// File: tb/sim_lpf_expander.sv
`timescale 1ns/1ps
module sim_lpf_expander;
  localparam int E   = 3;
  localparam int M   = 4;
  localparam int OFS = 2;
  localparam int BIAS_C = (1 << E) - 1 + OFS;
  localparam int NVEC = 12;

  // {code, expected single-precision word}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h00, 32'h0000_0000},
    {8'h80, 32'h8000_0000},
    {8'h10, 32'h3B80_0000},
    {8'h7F, 32'h3EF8_0000},
    {8'hFF, 32'hBEF8_0000},
    {8'h35, 32'h3CA8_0000},
    {8'h70, 32'h3E80_0000},
    {8'h08, 32'h3B00_0000},
    {8'h0F, 32'h3B70_0000},
    {8'h05, 32'h3AA0_0000},
    {8'h83, 32'hBA40_0000},
    {8'h01, 32'h3980_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_code;
  logic        out_valid;
  logic [31:0] out_word;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  lpf_expander #(.EXP_W(E), .MAN_W(M), .EXP_OFS(OFS)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic real ref_value(input logic [7:0] c);
    int  k = int'(c[6:4]);
    real m = real'(c[3:0]) / 16.0;
    real v;
    if (k == 0) v = m * (2.0 ** (1 - BIAS_C));
    else        v = (1.0 + m) * (2.0 ** (k - BIAS_C));
    return c[7] ? -v : v;
  endfunction

  function automatic real word_value(input logic [31:0] w);
    int  e = int'(w[30:23]);
    real v;
    if (e == 0) v = 0.0;
    else v = (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return w[31] ? -v : v;
  endfunction

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_code  = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'b0, out_valid}, 32'd0);
    check("R1 word in reset", out_word, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after release", {31'b0, out_valid}, 32'd0);

    // R4 R5 R6 R7 R3: table walk
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][39:32]);
      check("R2 valid", {31'b0, out_valid}, 32'd1);
      check("R3 R4 R5 R6 R7 vector", out_word, VEC[i][31:0]);
    end

    // R8: code changes without valid
    send(8'h35);
    in_code = 8'hFF;
    @(negedge clk);
    check("R8 valid low", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    check("R8 hold", out_word, 32'h3CA8_0000);

    // R2: back-to-back
    @(negedge clk);
    in_valid = 1'b1; in_code = 8'h10;
    @(negedge clk);
    in_code = 8'h83;
    check("R2 first of pair", out_word, 32'h3B80_0000);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second of pair", out_word, 32'hBA40_0000);
    check("R2 valid second", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    check("R2 valid drop", {31'b0, out_valid}, 32'd0);

    // R9 R10 R3: exhaustive round trip
    for (int c = 0; c < 256; c++) begin
      send(8'(c));
      checks++;
      if (word_value(out_word) != ref_value(8'(c)) || out_word[31] != c[7]) begin
        failures++;
        $display("FAIL R9 code=%h actual=%h expected=%g", c[7:0], out_word, ref_value(8'(c)));
      end
      checks++;
      if (out_word[30:23] == 8'hFF || (out_word[30:23] == 8'h00 && out_word[22:0] != '0)) begin
        failures++;
        $display("FAIL R10 code=%h actual=%h expected=finite normal or zero", c[7:0], out_word);
      end
    end

    // R1: reset in mid-run clears at once
    send(8'h7F);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear word", out_word, 32'd0);
    check("R1 async clear valid", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(8'h05);
    check("R1 usable after reset", out_word, 32'h3AA0_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule